// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital half of a 10-bit successive approximation converter. A conversion clock is derived from one of two enable strobes running at the system clock rate, each with its own set of integer dividers. The block starts a conversion either when software writes its start flag or when a falling edge arrives on an external trigger pin. During the conversion it drives a trial code to an external DAC and reads back one comparator bit. At the end it stores the 10-bit result and raises a one-cycle done pulse.

A conversion lasts exactly 43 conversion-clock ticks. The first 13 ticks are a sample window with the DAC held at zero. Each of the ten bits then takes three ticks: trial, settle and decide. The bits are resolved from the most significant down. In single mode the start flag clears itself once the result has been written. In repeat mode the block converts the same channel again and again until software clears the flag. In pin-trigger mode the flag only arms the block. A falling edge that arrives during a conversion throws that conversion away and starts over from the sample window.

Top module: `sar_seq`

## Requirements
- R1: After reset, `done`, `result`, `dac_code`, `ch_sel` and `start_flag` are all zero.
- R2: Conversion ticks occur on every Nth active cycle of the selected enable strobe (`cfg_src` 0 picks `src_a_en`, 1 picks `src_b_en`). `cfg_div` codes 0,1,2,3,4,5 give N = 1,2,3,4,6,12, and codes 6 and 7 give 12. The unselected strobe has no effect.
- R3: With `cfg_src`=1, code 0 divides by 2. The second source never runs undivided.
- R4: With `cfg_trig`=0, writing 1 to the start flag (`cfg_wr` with `cfg_start`=1) while idle starts a conversion on the next clock edge. The same write during a conversion does not restart it.
- R5: With `cfg_trig`=1, writing 1 to the start flag only arms the block. A conversion starts 2 clock edges after a low level on `trig_n` has passed the two-stage synchroniser, and only while the flag is set. Falling edges while the flag is clear are ignored.
- R6: In pin-trigger mode, a falling edge during a conversion aborts it without a done pulse and restarts from the first sample tick.
- R7: The result is written on the 43rd tick after the start: 13 sample ticks with `dac_code`=0, then 3 ticks per bit. `done` is high for exactly one cycle after that edge.
- R8: Bits are tried from bit 9 down to bit 0. On a bit's first tick it is set in `dac_code`. On its third tick it is kept if `cmp_hi`=1 (input at or above the DAC level) and cleared otherwise. The stored result equals the input level clamped to 0..1023.
- R9: With `cfg_mode`=0 (single), `start_flag` returns to 0 together with the done pulse.
- R10: With `cfg_mode`=1 (repeat), the next conversion begins right after each result while the start flag is set. Clearing the flag lets the running conversion finish and deliver its result, and then the block stops.
- R11: `ch_sel` takes `cfg_chan` when a conversion sequence starts. Changes to `cfg_chan` during the sequence do not affect it.
- R12: With `cfg_trig`=0, activity on `trig_n` neither starts nor alters a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_a_en | input | 1 | Enable strobe of conversion clock source A |
| src_b_en | input | 1 | Enable strobe of conversion clock source B |
| cfg_wr | input | 1 | Control write strobe, updates the start flag |
| cfg_start | input | 1 | Start flag value written by `cfg_wr` |
| cfg_src | input | 1 | Conversion clock source select |
| cfg_div | input | 3 | Divider code |
| cfg_trig | input | 1 | 0 software start, 1 pin trigger |
| cfg_mode | input | 1 | 0 single, 1 repeat |
| cfg_chan | input | 3 | Channel number to convert |
| trig_n | input | 1 | External trigger pin, falling edge active |
| cmp_hi | input | 1 | Comparator: input at or above DAC level |
| dac_code | output | 10 | Trial code for the DAC |
| ch_sel | output | 3 | Channel select for the analog mux |
| result | output | 10 | Last conversion result |
| done | output | 1 | One-cycle pulse when a result is written |
| start_flag | output | 1 | Current state of the start flag |

## Verification
The hardest case to reach is a pin-triggered restart. It needs a second synchronised falling edge that lands mid-conversion while the flag stays armed. If the aborted conversion leaked a done pulse or kept its partial DAC code, the only sign would be an early pulse or a changed code. The stimulus arms the block, drops the pin, raises it again about twenty cycles later, and drops it once more. The latency is then measured from the second edge only, while a per-cycle model checks `dac_code` over the whole aborted window. Stopping repeat mode is reached in a similar way, by clearing the flag partway through a running conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int RES_W        = 10;
    localparam int SAMPLE_TICKS = 13;
    localparam int STEP_TICKS   = 3;
    localparam int CH_W         = 3;
    localparam int DIV_W        = 4;
    localparam int DIV_CODE_W   = 3;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_TRIAL  = 2'd2
    } phase_e;

    typedef enum logic {
        SRC_A = 1'b0,
        SRC_B = 1'b1
    } clk_src_e;

    typedef enum logic {
        TRIG_SOFT = 1'b0,
        TRIG_PIN  = 1'b1
    } trig_e;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_REPEAT = 1'b1
    } run_mode_e;

    typedef struct packed {
        clk_src_e              src;
        logic [DIV_CODE_W-1:0] div_code;
        trig_e                 trig;
        run_mode_e             mode;
    } cfg_t;

    // Divide ratio for a source/code pair; source B has no bypass.
    function automatic logic [DIV_W-1:0] div_ratio(clk_src_e src,
                                                   logic [DIV_CODE_W-1:0] code);
        logic [DIV_W-1:0] r;
        case (code)
            3'd0:    r = (src == SRC_B) ? DIV_W'(2) : DIV_W'(1);
            3'd1:    r = DIV_W'(2);
            3'd2:    r = DIV_W'(3);
            3'd3:    r = DIV_W'(4);
            3'd4:    r = DIV_W'(6);
            default: r = DIV_W'(12);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sar_clkdiv.sv
`timescale 1ns/1ps
module sar_clkdiv
    import sar_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  logic                  restart,
    input  logic                  src_a_en,
    input  logic                  src_b_en,
    input  clk_src_e              src,
    input  logic [DIV_CODE_W-1:0] code,
    output logic                  tick
);

    logic [DIV_W-1:0] ratio;
    logic [DIV_W-1:0] cnt;
    logic             en;

    always_comb begin
        ratio = div_ratio(src, code);
        en    = (src == SRC_B) ? src_b_en : src_a_en;
        tick  = run && !restart && en && (cnt == ratio - DIV_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= tick ? '0 : cnt + DIV_W'(1);
        end
    end

    AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < ratio)); // R2

    AST_SRC_B_DIVIDED: assert property (@(posedge clk) disable iff (rst)
        (run && src == SRC_B) |-> (ratio >= DIV_W'(2))); // R3

endmodule

// File: rtl/sar_edge_sync.sv
`timescale 1ns/1ps
module sar_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall
);

    logic meta_q;
    logic sync_q;
    logic hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            hist_q <= 1'b0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign fall = hist_q && !sync_q;

endmodule

// File: rtl/sar_approx.sv
`timescale 1ns/1ps
module sar_approx #(
    parameter int RES_W = 10,
    localparam int IDX_W = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             set_en,
    input  logic             decide_en,
    input  logic [IDX_W-1:0] idx,
    input  logic             cmp_hi,
    output logic [RES_W-1:0] sar,
    output logic [RES_W-1:0] decided
);

    logic [RES_W-1:0] mask;
    logic [RES_W-1:0] low_mask;

    always_comb begin
        mask     = RES_W'(1) << idx;
        low_mask = {mask[RES_W-2:0], 1'b0} - RES_W'(1);
        decided  = cmp_hi ? sar : (sar & ~mask);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sar <= '0;
        end else if (set_en) begin
            sar <= sar | mask;
        end else if (decide_en) begin
            sar <= decided;
        end
    end

    // A trial bit is only raised while it and every lower bit are still clear.
    AST_TRIAL_MSB_FIRST: assert property (@(posedge clk) disable iff (rst)
        (set_en && !clear) |-> ((sar & low_mask) == '0)); // R8

endmodule

// File: rtl/sar_seq.sv
`timescale 1ns/1ps
module sar_seq
    import sar_seq_pkg::*;
#(
    parameter int RES_BITS = RES_W,
    parameter int CHAN_W   = CH_W,
    parameter int N_SAMPLE = SAMPLE_TICKS,
    parameter int N_STEP   = STEP_TICKS,
    localparam int IDX_W   = $clog2(RES_BITS),
    localparam int SCNT_W  = $clog2(N_SAMPLE),
    localparam int STEP_W  = $clog2(N_STEP)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  src_a_en,
    input  logic                  src_b_en,
    input  logic                  cfg_wr,
    input  logic                  cfg_start,
    input  logic                  cfg_src,
    input  logic [DIV_CODE_W-1:0] cfg_div,
    input  logic                  cfg_trig,
    input  logic                  cfg_mode,
    input  logic [CHAN_W-1:0]     cfg_chan,
    input  logic                  trig_n,
    input  logic                  cmp_hi,
    output logic [RES_BITS-1:0]   dac_code,
    output logic [CHAN_W-1:0]     ch_sel,
    output logic [RES_BITS-1:0]   result,
    output logic                  done,
    output logic                  start_flag
);

    cfg_t cfg;
    always_comb begin
        cfg.src      = clk_src_e'(cfg_src);
        cfg.div_code = cfg_div;
        cfg.trig     = trig_e'(cfg_trig);
        cfg.mode     = run_mode_e'(cfg_mode);
    end

    phase_e              ph;
    logic [SCNT_W-1:0]   scnt;
    logic [STEP_W-1:0]   step;
    logic [IDX_W-1:0]    bidx;
    logic                start_q;
    logic                start_d;
    logic [CHAN_W-1:0]   ch_q;
    logic [RES_BITS-1:0] sar_val;
    logic [RES_BITS-1:0] sar_dec;

    logic pin_fall;
    logic go;
    logic tick;
    logic in_trial;
    logic last_step;
    logic last_tick;
    logic set_en;
    logic decide_en;
    logic cont;

    sar_edge_sync u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin  (trig_n),
        .fall (pin_fall)
    );

    sar_clkdiv u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (ph != PH_IDLE),
        .restart  (go),
        .src_a_en (src_a_en),
        .src_b_en (src_b_en),
        .src      (cfg.src),
        .code     (cfg.div_code),
        .tick     (tick)
    );

    always_comb begin
        go = (cfg_wr && cfg_start && cfg.trig == TRIG_SOFT && ph == PH_IDLE)
          || (pin_fall && cfg.trig == TRIG_PIN && start_q);
        in_trial  = (ph == PH_TRIAL);
        last_step = (step == STEP_W'(N_STEP - 1));
        set_en    = tick && in_trial && (step == '0);
        decide_en = tick && in_trial && last_step;
        last_tick = decide_en && (bidx == '0);

        start_d = start_q;
        if (last_tick && cfg.mode == MODE_SINGLE) begin
            start_d = 1'b0;
        end
        if (cfg_wr) begin
            start_d = cfg_start;
        end
        cont = (cfg.mode == MODE_REPEAT) && start_d;
    end

    sar_approx #(.RES_W(RES_BITS)) u_sar (
        .clk       (clk),
        .rst       (rst),
        .clear     (go || last_tick),
        .set_en    (set_en),
        .decide_en (decide_en),
        .idx       (bidx),
        .cmp_hi    (cmp_hi),
        .sar       (sar_val),
        .decided   (sar_dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            scnt    <= '0;
            step    <= '0;
            bidx    <= '0;
            start_q <= 1'b0;
            ch_q    <= '0;
            result  <= '0;
            done    <= 1'b0;
        end else begin
            done    <= last_tick;
            start_q <= start_d;
            if (last_tick) begin
                result <= sar_dec;
            end
            if (go) begin
                ph   <= PH_SAMPLE;
                scnt <= '0;
                step <= '0;
                bidx <= IDX_W'(RES_BITS - 1);
                ch_q <= cfg_chan;
            end else if (tick) begin
                case (ph)
                    PH_SAMPLE: begin
                        if (scnt == SCNT_W'(N_SAMPLE - 1)) begin
                            ph   <= PH_TRIAL;
                            scnt <= '0;
                            step <= '0;
                            bidx <= IDX_W'(RES_BITS - 1);
                        end else begin
                            scnt <= scnt + SCNT_W'(1);
                        end
                    end
                    PH_TRIAL: begin
                        if (last_step) begin
                            step <= '0;
                            if (bidx == '0) begin
                                ph   <= cont ? PH_SAMPLE : PH_IDLE;
                                scnt <= '0;
                                bidx <= IDX_W'(RES_BITS - 1);
                            end else begin
                                bidx <= bidx - IDX_W'(1);
                            end
                        end else begin
                            step <= step + STEP_W'(1);
                        end
                    end
                    default: ph <= PH_IDLE;
                endcase
            end
        end
    end

    assign dac_code   = sar_val;
    assign ch_sel     = ch_q;
    assign start_flag = start_q;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

    AST_SAMPLE_DAC_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_SAMPLE) |-> (dac_code == '0)); // R7

    AST_SINGLE_CLEARS_START: assert property (@(posedge clk) disable iff (rst)
        (done && !$past(cfg_mode) && !$past(cfg_wr)) |-> !start_flag); // R9

    AST_CHAN_HELD: assert property (@(posedge clk) disable iff (rst)
        (ph != PH_IDLE && $past(ph) != PH_IDLE && !$past(go)) |-> $stable(ch_sel)); // R11

endmodule

// File: tb/sar_seq_bench.sv
`timescale 1ns/1ps
module sar_seq_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       src_a_en = 1'b1, src_b_en = 1'b1;
    logic       cfg_wr = 1'b0, cfg_start = 1'b0, cfg_src = 1'b0;
    logic [2:0] cfg_div = 3'd0;
    logic       cfg_trig = 1'b0, cfg_mode = 1'b0;
    logic [2:0] cfg_chan = 3'd0;
    logic       trig_n = 1'b1;
    logic       cmp_hi;
    logic [9:0] dac_code, result;
    logic [2:0] ch_sel;
    logic       done, start_flag;
    int         vin = 0;

    always #2 clk = ~clk;

    assign cmp_hi = (vin >= int'(dac_code));

    sar_seq u_sar_seq (
        .clk(clk), .rst(rst), .src_a_en(src_a_en), .src_b_en(src_b_en),
        .cfg_wr(cfg_wr), .cfg_start(cfg_start), .cfg_src(cfg_src),
        .cfg_div(cfg_div), .cfg_trig(cfg_trig), .cfg_mode(cfg_mode),
        .cfg_chan(cfg_chan), .trig_n(trig_n), .cmp_hi(cmp_hi),
        .dac_code(dac_code), .ch_sel(ch_sel), .result(result),
        .done(done), .start_flag(start_flag)
    );

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ratio_of(input bit src, input int code);
        case (code)
            0: return src ? 2 : 1;
            1: return 2;
            2: return 3;
            3: return 4;
            4: return 6;
            default: return 12;
        endcase
    endfunction

    function automatic int clamp(input int v);
        return v > 1023 ? 1023 : (v < 0 ? 0 : v);
    endfunction

    // Behavioural reference: tick counting with integers.
    bit m_s1, m_s2, m_s3, m_run, m_done, m_start;
    bit m_fall, m_go, m_tick, m_en, m_fin, m_st;
    int m_div, m_k, m_sar, m_res, m_ch, m_d, m_b;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_run = 0; m_done = 0; m_start = 0;
            m_div = 0; m_k = 0; m_sar = 0; m_res = 0; m_ch = 0;
        end else begin
            m_fall = m_s3 && !m_s2;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = trig_n;
            m_d  = ratio_of(cfg_src, int'(cfg_div));
            m_en = cfg_src ? src_b_en : src_a_en;
            m_go = (cfg_wr && cfg_start && !cfg_trig && !m_run)
                || (m_fall && cfg_trig && m_start);
            m_tick = m_run && m_en && (m_div == m_d - 1) && !m_go;
            m_fin = 0; m_done = 0; m_st = m_start;
            if (m_go) begin
                m_run = 1; m_div = 0; m_k = 0; m_sar = 0; m_ch = int'(cfg_chan);
            end else if (m_tick) begin
                m_div = 0; m_k++;
                if (m_k >= 14 && (m_k - 14) % 3 == 0)
                    m_sar = m_sar | (1 << (9 - (m_k - 14) / 3));
                if (m_k >= 16 && (m_k - 16) % 3 == 0) begin
                    m_b = 9 - (m_k - 16) / 3;
                    if (!(vin >= m_sar)) m_sar = m_sar & ~(1 << m_b);
                end
                if (m_k == 43) m_fin = 1;
            end else if (m_run && m_en) begin
                m_div++;
            end
            if (m_fin && !cfg_mode) m_st = 0;
            if (cfg_wr) m_st = cfg_start;
            if (m_fin) begin
                m_res = m_sar; m_done = 1; m_sar = 0; m_k = 0;
                if (!(cfg_mode && m_st)) m_run = 0;
            end
            m_start = m_st;
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(done == m_done, "R7", "done", done, m_done);
            chk(int'(result) == m_res, "R8", "result", result, m_res);
            chk(start_flag == m_start, "R9", "start_flag", start_flag, m_start);
            chk(int'(dac_code) == m_sar, "R8", "dac_code", dac_code, m_sar);
            chk(int'(ch_sel) == m_ch, "R11", "ch_sel", ch_sel, m_ch);
        end
    end

    task automatic wr_start(input bit v);
        @(negedge clk); cfg_wr = 1'b1; cfg_start = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic measure(input int lim, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!done && n < lim);
    endtask

    task automatic idle_no_done(input int cyc, input string req);
        bit seen = 0;
        for (int i = 0; i < cyc; i++) begin @(negedge clk); if (done) seen = 1; end
        chk(!seen, req, "no done pulse", seen, 0);
    endtask

    task automatic report;
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
    end

    initial begin
        int n, t;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(done == 0 && start_flag == 0, "R1", "done/start after reset", {done, start_flag}, 0);
        chk(result == 0 && dac_code == 0 && ch_sel == 0, "R1", "data after reset", result, 0);

        // R7/R8/R9 basic software conversion
        vin = 341; cfg_chan = 3'd1;
        wr_start(1);
        measure(100, n);
        chk(n == 43, "R7", "latency div1", n, 43);
        chk(int'(result) == 341, "R8", "result", result, 341);
        chk(start_flag == 0, "R9", "start self clear", start_flag, 0);

        // R2 divider codes on source A
        for (int c = 0; c < 8; c++) begin
            cfg_div = 3'(c); vin = 97 * c + 3;
            wr_start(1);
            measure(700, n);
            chk(n == 43 * ratio_of(0, c), "R2", "latency per code", n, 43 * ratio_of(0, c));
            chk(int'(result) == clamp(vin), "R8", "result per code", result, clamp(vin));
        end

        // R3 source B, code 0 divides by 2; R2 source A strobe is ignored
        cfg_src = 1'b1; cfg_div = 3'd0; src_a_en = 1'b0; vin = 1023;
        wr_start(1);
        measure(200, n);
        chk(n == 86, "R3", "source B code0 latency", n, 86);
        chk(int'(result) == 1023, "R8", "full scale", result, 1023);
        src_a_en = 1'b1;

        // R2 selected strobe gates progress
        cfg_src = 1'b0; src_a_en = 1'b0; vin = 5000;
        wr_start(1);
        idle_no_done(60, "R2");
        src_a_en = 1'b1;
        measure(100, n);
        chk(n == 43, "R2", "resume after strobe", n, 43);
        chk(int'(result) == 1023, "R8", "clamped top", result, 1023);

        // R4 start write while busy is ignored
        vin = 0;
        wr_start(1);
        repeat (8) @(negedge clk);
        wr_start(1);
        measure(100, n);
        chk(n + 10 == 43, "R4", "no restart by write", n + 10, 43);
        chk(int'(result) == 0, "R8", "zero input", result, 0);

        // R12 pin ignored in software mode
        vin = 512;
        wr_start(1);
        t = 0;
        for (int i = 0; i < 10; i++) begin trig_n = ~trig_n; @(negedge clk); t++; end
        trig_n = 1'b1;
        measure(100, n);
        chk(n + t == 43, "R12", "pin in soft mode", n + t, 43);
        chk(int'(result) == 512, "R8", "mid scale", result, 512);

        // R5 pin trigger arms only, then falling edge starts
        cfg_trig = 1'b1; vin = 700;
        repeat (4) @(negedge clk);
        wr_start(1);
        idle_no_done(20, "R5");
        chk(dac_code == 0 && start_flag == 1, "R5", "armed idle", dac_code, 0);
        trig_n = 1'b0;
        measure(100, n);
        chk(n == 46, "R5", "pin start latency", n, 46);
        chk(int'(result) == 700, "R8", "pin result", result, 700);
        chk(start_flag == 0, "R9", "pin single clears", start_flag, 1'b0);

        // R5 falls while disarmed are ignored
        trig_n = 1'b1; repeat (3) @(negedge clk);
        trig_n = 1'b0;
        idle_no_done(70, "R5");

        // R6 retrigger mid conversion
        trig_n = 1'b1; vin = 222;
        wr_start(1);
        repeat (3) @(negedge clk);
        trig_n = 1'b0;
        repeat (20) @(negedge clk);
        trig_n = 1'b1;
        repeat (3) @(negedge clk);
        trig_n = 1'b0;
        measure(100, n);
        chk(n == 46, "R6", "restart latency", n, 46);
        chk(int'(result) == 222, "R6", "restart result", result, 222);
        trig_n = 1'b1;

        // R10 repeat mode and R11 channel latch
        cfg_trig = 1'b0; cfg_mode = 1'b1; cfg_chan = 3'd5; vin = 100;
        repeat (4) @(negedge clk);
        wr_start(1);
        repeat (2) @(negedge clk);
        cfg_chan = 3'd2;
        measure(100, n);
        chk(n + 2 == 43, "R10", "first repeat latency", n + 2, 43);
        chk(int'(ch_sel) == 5, "R11", "channel held", ch_sel, 5);
        vin = 900;
        measure(100, n);
        chk(n == 43, "R10", "back to back", n, 43);
        chk(int'(result) == 900, "R10", "second result", result, 900);
        repeat (10) @(negedge clk);
        wr_start(0);
        measure(100, n);
        chk(n + 12 == 43, "R10", "finish after clear", n + 12, 43);
        chk(start_flag == 0, "R10", "flag cleared", start_flag, 0);
        idle_no_done(100, "R10");
        chk(int'(ch_sel) == 5, "R11", "channel after stop", ch_sel, 5);

        report();
    end

endmodule